// File: doc/BRIEF.md
# Width-Converting FIFO Read Port

This block turns a FIFO that stores whole 36-bit entries into a read port whose width is chosen at reset: the full 36 bits, 18 bits or 9 bits. The memory is always read one whole entry at a time. The narrowing happens after an entry leaves the memory. At 18 or 9 bits, the first read of an entry pops it from the FIFO and puts its first portion on the port. A holding register keeps the rest of the entry, and the following reads take the remaining portions from it. The FIFO is popped again only once the last portion has been sent.

The portion order is picked at reset. The most-significant-first order sends the upper lanes first. The least-significant-first order starts at bit 0. The width and order selects are captured while reset is held. The values present on the last clock edge of reset stay in force until the next reset, whatever the pins do afterwards.

The FIFO side is a show-ahead interface. The head entry is valid whenever the empty flag is low, and a pop moves to the next entry on the clock edge. On the port side, a read is accepted on a rising edge when the read enable and the ready output are both high. The new portion appears on the data output just after that edge.

Top module: `busmatch_rd_port`

## Requirements
- R1: `fifoPop` is high only in a cycle where `rdEn` and `portReady` are high and no portion of the previous entry remains. After the first pop, consecutive pops are exactly 1, 2 or 4 accepted reads apart in 36-, 18- and 9-bit mode.
- R2: Width encoding: `busMatch`=0 gives 36 bits, `busMatch`=1 with `busSize`=0 gives 18 bits, and `busMatch`=1 with `busSize`=1 gives 9 bits. `bigEnd`=1 selects most-significant-first order. All three are sampled on every clock edge where `rstN` is low. Changes after reset has been released have no effect.
- R3: In 36-bit mode, each accepted read pops one entry. The whole entry appears on `portData` after the clock edge of that read.
- R4: In 18-bit mode, each entry is sent in two reads as bits 35:18 and bits 17:0. Most-significant-first order sends 35:18 first; the other order sends 17:0 first. The value is placed on `portData[17:0]`, and `portData[35:18]` is zero.
- R5: In 9-bit mode, each entry is sent in four reads. Lane k is bits 9k+8:9k. Most-significant-first order sends lanes 3,2,1,0; the other order sends lanes 0,1,2,3. The lane is placed on `portData[8:0]`, and `portData[35:9]` is zero.
- R6: `bigEnd` has no effect in 36-bit mode.
- R7: `portReady` is high exactly when the FIFO is not empty or portions of the current entry remain. It stays high while portions remain even after the FIFO has become empty.
- R8: `portData` keeps its value in every cycle without an accepted read. A read enable while `portReady` is low changes neither `portData` nor the FIFO.
- R9: While `rstN` is low, `portReady` and `fifoPop` are low. After reset, `portData` is zero until the first accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; width and order selects are captured while it is low |
| busMatch | input | 1 | 0 selects the full 36-bit port, 1 selects a narrow port |
| busSize | input | 1 | For a narrow port: 0 selects 18 bits, 1 selects 9 bits |
| bigEnd | input | 1 | 1 selects most-significant-first portion order |
| fifoData | input | 36 | Head entry of the FIFO (show-ahead) |
| fifoEmpty | input | 1 | FIFO holds no entry |
| fifoPop | output | 1 | Removes the head entry on this clock edge |
| rdEn | input | 1 | Port read request |
| portData | output | 36 | Registered port output; bits above the selected width are zero |
| portReady | output | 1 | A read would be accepted in this cycle |

## Verification
The checker relies on the FIFO behaving as a show-ahead queue: `fifoEmpty` is low exactly when `fifoData` holds a valid head entry, and a pop removes that entry on the same edge. It also relies on the select pins never being changed while reset is low in a way that matters after release; only their last reset-time values are used. The bench meets these assumptions with a small queue model whose read pointer advances only on `fifoPop` and is cleared during reset. Entries are pushed only between clock edges, and the select pins are driven before reset is released. In one scenario the pins are deliberately changed after release, to show that such changes are ignored.

// File: rtl/bmrp_pkg.sv
package bmrp_pkg;
  localparam int LANES      = 4;
  localparam int LANE_IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    MODE_LONG = 2'd0,
    MODE_WORD = 2'd1,
    MODE_BYTE = 2'd2
  } busMode_e;

  typedef struct packed {
    logic                  load;
    logic                  advance;
    busMode_e              mode;
    logic [LANE_IDX_W-1:0] lane;
  } ctrlStrb_t;
endpackage

// File: rtl/bmrp_ctrl.sv
module bmrp_ctrl
  import bmrp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busMatch,
  input  logic      busSize,
  input  logic      bigEnd,
  input  logic      fifoEmpty,
  input  logic      rdEn,
  output logic      fifoPop,
  output logic      portReady,
  output ctrlStrb_t strb
);
  localparam logic [LANE_IDX_W-1:0] ONE = LANE_IDX_W'(1);

  busMode_e              modeQ;
  logic                  bigQ;
  logic [LANE_IDX_W-1:0] leftQ;
  logic [LANE_IDX_W-1:0] lastIdx;
  logic [LANE_IDX_W-1:0] posIdx;
  logic                  readOk;
  logic                  loadNow;
  logic                  advNow;

  // index of the final portion for the captured width
  always_comb begin
    unique case (modeQ)
      MODE_WORD: lastIdx = LANE_IDX_W'(LANES / 2 - 1);
      MODE_BYTE: lastIdx = LANE_IDX_W'(LANES - 1);
      default:   lastIdx = '0;
    endcase
  end

  assign portReady = rstN & (~fifoEmpty | (leftQ != '0));
  assign readOk    = rdEn & portReady;
  assign loadNow   = readOk & (leftQ == '0);
  assign advNow    = readOk & (leftQ != '0);
  assign fifoPop   = loadNow;

  // sequence position of the portion sent by this read
  assign posIdx = loadNow ? '0 : lastIdx - leftQ + ONE;

  always_comb begin
    strb.load    = loadNow;
    strb.advance = advNow;
    strb.mode    = modeQ;
    strb.lane    = (bigQ && modeQ != MODE_LONG) ? lastIdx - posIdx : posIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      if (!busMatch)    modeQ <= MODE_LONG;
      else if (busSize) modeQ <= MODE_BYTE;
      else              modeQ <= MODE_WORD;
      bigQ  <= bigEnd;
      leftQ <= '0;
    end else if (loadNow) begin
      leftQ <= lastIdx;
    end else if (advNow) begin
      leftQ <= leftQ - ONE;
    end
  end
endmodule

// File: rtl/bmrp_dpath.sv
module bmrp_dpath
  import bmrp_pkg::*;
#(
  parameter  int LANE_W = 9,
  localparam int WORD_W = LANE_W * LANES,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [WORD_W-1:0] fifoData,
  output logic [WORD_W-1:0] portData
);
  logic [WORD_W-1:0] holdQ;
  logic [WORD_W-1:0] outQ;
  logic [WORD_W-1:0] srcWord;
  logic [WORD_W-1:0] nextOut;
  logic [LANE_W-1:0] byteLane [LANES];
  logic [HALF_W-1:0] halfLane [2];

  assign srcWord = strb.load ? fifoData : holdQ;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_byte
    assign byteLane[gi] = srcWord[gi*LANE_W +: LANE_W];
  end
  for (genvar gh = 0; gh < 2; gh++) begin : g_half
    assign halfLane[gh] = srcWord[gh*HALF_W +: HALF_W];
  end

  always_comb begin
    unique case (strb.mode)
      MODE_WORD: nextOut = {{(WORD_W-HALF_W){1'b0}}, halfLane[strb.lane[0]]};
      MODE_BYTE: nextOut = {{(WORD_W-LANE_W){1'b0}}, byteLane[strb.lane]};
      default:   nextOut = srcWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
      outQ  <= '0;
    end else begin
      if (strb.load) holdQ <= fifoData;
      if (strb.load || strb.advance) outQ <= nextOut;
    end
  end

  assign portData = outQ;
endmodule

// File: rtl/busmatch_rd_port.sv
module busmatch_rd_port
  import bmrp_pkg::*;
#(
  parameter  int LANE_W = 9,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMatch,
  input  logic              busSize,
  input  logic              bigEnd,
  input  logic [WORD_W-1:0] fifoData,
  input  logic              fifoEmpty,
  output logic              fifoPop,
  input  logic              rdEn,
  output logic [WORD_W-1:0] portData,
  output logic              portReady
);
  ctrlStrb_t strb;

  bmrp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busMatch(busMatch), .busSize(busSize),
    .bigEnd(bigEnd), .fifoEmpty(fifoEmpty), .rdEn(rdEn),
    .fifoPop(fifoPop), .portReady(portReady), .strb(strb)
  );

  bmrp_dpath #(.LANE_W(LANE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .fifoData(fifoData), .portData(portData)
  );
endmodule

// File: rtl/busmatch_rd_port_chk.sv
module busmatch_rd_port_chk #(
  parameter int WORD_W = 36,
  parameter int LANE_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              busMatch,
  input logic              busSize,
  input logic              fifoEmpty,
  input logic              fifoPop,
  input logic              rdEn,
  input logic [WORD_W-1:0] portData,
  input logic              portReady
);
  logic [2:0] nQ;
  logic [2:0] readsSince;
  logic       seenPop;
  logic       accepted;

  assign accepted = rdEn && portReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nQ         <= !busMatch ? 3'd1 : (busSize ? 3'd4 : 3'd2);
      readsSince <= '0;
      seenPop    <= 1'b0;
    end else if (accepted) begin
      readsSince <= fifoPop ? 3'd1 : readsSince + 3'd1;
      if (fifoPop) seenPop <= 1'b1;
    end
  end

  // R1
  pop_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (rdEn && portReady && !fifoEmpty));

  // R1
  pop_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoPop && seenPop) |-> (readsSince == nQ));

  // R7
  ready_model_chk: assert property (@(posedge clk) disable iff (!rstN)
    portReady == (!fifoEmpty || (seenPop && readsSince != nQ)));

  // R4
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nQ == 3'd2) |-> (portData[WORD_W-1:WORD_W/2] == '0));

  // R5
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nQ == 3'd4) |-> (portData[WORD_W-1:LANE_W] == '0));

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> $stable(portData));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!portReady && !fifoPop));
endmodule

bind busmatch_rd_port busmatch_rd_port_chk #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .busMatch(busMatch), .busSize(busSize),
  .fifoEmpty(fifoEmpty), .fifoPop(fifoPop), .rdEn(rdEn),
  .portData(portData), .portReady(portReady)
);

// File: tb/busmatch_rd_port_bench.sv
`timescale 1ns/1ps
module busmatch_rd_port_bench;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busMatch = 1'b0, busSize = 1'b0, bigEnd = 1'b0;
  logic [W-1:0] fifoData;
  logic         fifoEmpty, fifoPop, rdEn = 1'b0;
  logic [W-1:0] portData;
  logic         portReady;

  logic [W-1:0] mem [16];
  int           wrPtr = 0;
  int           rdPtr;
  int           popCnt;
  int           errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  assign fifoEmpty = (rdPtr == wrPtr);
  assign fifoData  = mem[rdPtr % 16];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr  <= 0;
      popCnt <= 0;
    end else if (fifoPop) begin
      rdPtr  <= rdPtr + 1;
      popCnt <= popCnt + 1;
    end
  end

  busmatch_rd_port u_busmatch_rd_port (
    .clk(clk), .rstN(rstN), .busMatch(busMatch), .busSize(busSize),
    .bigEnd(bigEnd), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .fifoPop(fifoPop), .rdEn(rdEn), .portData(portData), .portReady(portReady)
  );

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic m, input logic s, input logic b);
    @(negedge clk);
    rstN = 1'b0; rdEn = 1'b0;
    busMatch = m; busSize = s; bigEnd = b;
    wrPtr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic push(input logic [W-1:0] w);
    mem[wrPtr % 16] = w;
    wrPtr++;
  endtask

  task automatic readOne();
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic logic [W-1:0] piece(input logic [W-1:0] w, input int n, input int k);
    int pw = W / n;
    return (w >> (pw * k)) & ((64'd1 << pw) - 1);
  endfunction

  // R9 / R7: quiet after reset with an empty FIFO
  task automatic tReset();
    doReset(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check(portData, '0, "R9 data zero after reset");
    check({35'd0, portReady}, '0, "R7 ready low when empty");
    readOne();
    check(portData, '0, "R8 read ignored when not ready");
    check(popCnt, 0, "R8 no pop when not ready");
  endtask

  // R1 R3 R4 R5 R6: portion order for one mode, two entries
  task automatic tMode(input logic m, input logic s, input logic b, input string tag);
    int n;
    logic [W-1:0] words [2];
    words[0] = 36'h9_8765_4321;
    words[1] = 36'hA_5C3E_1F07;
    n = !m ? 1 : (s ? 4 : 2);
    doReset(m, s, b);
    push(words[0]); push(words[1]);
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < n; p++) begin
        int k;
        k = (b && n > 1) ? n - 1 - p : p;
        readOne();
        check(portData, piece(words[e], n, k), tag);
        check(popCnt, e + 1, {tag, " R1 pop count"});
      end
    end
    check({35'd0, portReady}, '0, {tag, " R7 ready low when drained"});
  endtask

  // R7: ready stays high with portions left while FIFO is empty
  task automatic tReadyTail();
    doReset(1'b1, 1'b1, 1'b0);
    push(36'h1_2345_6789);
    readOne();
    check({35'd0, fifoEmpty}, 36'd1, "R7 fifo empty after pop");
    check({35'd0, portReady}, 36'd1, "R7 ready while portions remain");
    repeat (3) readOne();
    check({35'd0, portReady}, '0, "R7 ready low after last portion");
  endtask

  // R2 R8: pins changed after reset are ignored; data held between reads
  task automatic tPinsIgnored();
    logic [W-1:0] w;
    logic [W-1:0] held;
    w = 36'hF_EDCB_A987;
    doReset(1'b1, 1'b1, 1'b0);
    busMatch = 1'b0; busSize = 1'b0; bigEnd = 1'b1;
    push(w);
    readOne();
    check(portData, piece(w, 4, 0), "R2 byte little kept after pin change");
    held = portData;
    repeat (4) @(negedge clk);
    check(portData, held, "R8 data held without read");
    readOne();
    check(portData, piece(w, 4, 1), "R2 second lane order kept");
  endtask

  initial begin
    fork
      begin
        tReset();
        tMode(1'b0, 1'b0, 1'b0, "R3 long");
        tMode(1'b0, 1'b1, 1'b1, "R6 long with bigEnd");
        tMode(1'b1, 1'b0, 1'b1, "R4 word big");
        tMode(1'b1, 1'b0, 1'b0, "R4 word little");
        tMode(1'b1, 1'b1, 1'b1, "R5 byte big");
        tMode(1'b1, 1'b1, 1'b0, "R5 byte little");
        tReadyTail();
        tPinsIgnored();
      end
      begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule